// File: doc/BRIEF.md
# Tile Power Governor

This block decides, for a single processor tile, the supply rail and the oscillator frequency code of the core. It reads two signs of load. One is the occupancy of the core's input FIFO. The other is how many cycles the core spends stalled. Once per fixed window it turns these into a load sample and smooths the samples with a first-order IIR filter whose shift is configurable. A hysteresis band around two thresholds then picks the high or the low rail. A software override and a static configuration can also pick the rail and the frequency, and either one takes precedence over the hardware loop.

When the chosen rail differs from the present one, the block stops the core clock. It then enables the power gates of the new rail one at a time, at a pace set by a selectable ramp profile. Only after that does it release the old rail's gates. A settling interval follows, then a one-cycle done pulse, and the clock starts again. Only the digital gate enables, the clock enable and the frequency code leave the block. The analog supplies are outside it.

Top module: `tile_power_governor`

## Requirements
- R1: After reset the rail is high (`rail_now` = 2), every `gate_high` bit is 1, every `gate_low` bit is 0, `core_clk_en` is 1, `switch_done` is 0 and `freq_code` is all ones.
- R2: A window lasts WIN cycles. At the last cycle of each window the block forms the sample x = `fifo_level` + WIN − (stalled cycles in that window) and updates the filter as y ← y + ((x − y) >>> `filt_shift`), rounding toward minus infinity. y is 0 after reset.
- R3: The hardware loop selects the high rail when y > `thr_high` and the low rail when y < `thr_low`. Inside the band it keeps its previous choice, and it starts out on the high rail. Its frequency code is all ones on the high rail and HW_LOW_FREQ on the low rail.
- R4: The source is chosen in this order: software override (`sw_en`) first, then static configuration (`st_en`), then the hardware loop.
- R5: Rail codes are 0 = disconnected, 1 = low, 2 = high, and 3 is treated as high. A request for code 0 is ignored while `fifo_level` is non-zero: the rail stays as it is and no switch starts.
- R6: Each rail change drives `core_clk_en` low from the cycle after the request. The new rail's gates then turn on one per P cycles, where P = 1, 2, 4 for `ramp_sel` = 0, 1, 2 and P = 4 for `ramp_sel` = 3. The clock is never enabled while both rails have a gate on.
- R7: The old rail's gates stay fully on until every gate of the new rail is on, and they then all turn off together. After SETTLE_CYC settling cycles the switch completes. Between two powered rails the clock is off for exactly GATE_N·P + SETTLE_CYC + 2 cycles. A switch to the disconnected rail takes SETTLE_CYC + 3 cycles.
- R8: `switch_done` is a one-cycle pulse in the last halted cycle. The clock restarts in the next cycle unless the new rail is disconnected, in which case all gates stay off and the clock stays stopped.
- R9: While the rail does not change, `freq_code` takes the selected frequency one cycle later. During a switch it holds its old value, and the new code appears together with `switch_done`.
- R10: Whenever the core clock is enabled, exactly one rail has all of its gates on and the other has none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fifo_level | input | OCC_W | Occupancy of the core's input FIFO |
| stall | input | 1 | Core stalled in this cycle |
| sw_en | input | 1 | Software override active |
| sw_rail | input | 2 | Software rail code |
| sw_freq | input | FREQ_W | Software frequency code |
| st_en | input | 1 | Static configuration active |
| st_rail | input | 2 | Static rail code |
| st_freq | input | FREQ_W | Static frequency code |
| filt_shift | input | K_W | Filter shift k |
| thr_high | input | M_W | Upper hysteresis threshold |
| thr_low | input | M_W | Lower hysteresis threshold |
| ramp_sel | input | 2 | Ramp profile: 0 fast, 1 medium, 2/3 slow |
| freq_code | output | FREQ_W | Oscillator frequency code |
| core_clk_en | output | 1 | Core clock enable |
| gate_high | output | GATE_N | High-rail power gate enables |
| gate_low | output | GATE_N | Low-rail power gate enables |
| switch_done | output | 1 | Switch-complete pulse |
| rail_now | output | 2 | Rail currently applied |

## Verification
The bench builds the block with OCC_W=6, WIN=16, GATE_N=4, SETTLE_CYC=3, FREQ_W=6 and HW_LOW_FREQ=20. The short 16-cycle window lets a 3-window filter settling with shift 2 be told apart, by latency alone, from the 1-window response with shift 0. Four gates per rail give halt lengths of 9, 13 and 21 cycles for the three profiles, so an error of one cycle in the step pacing or in the settling count shows up. With a 6-bit occupancy the thresholds can be placed so that the sample lands exactly on the upper threshold, which exercises the strict comparison.

// File: rtl/tpg_pkg.sv
// Shared definitions for the tile power governor.
// Assumes rail codes are 2 bits wide; code 3 is folded onto the high rail.
package tpg_pkg;
    localparam logic [1:0] RAIL_OFF  = 2'd0;
    localparam logic [1:0] RAIL_LOW  = 2'd1;
    localparam logic [1:0] RAIL_HIGH = 2'd2;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_RAMP_ON,
        SQ_RAMP_OFF,
        SQ_SETTLE,
        SQ_DONE
    } seq_state_e;

    // Map a raw rail code to a legal rail.
    function automatic logic [1:0] norm_rail(input logic [1:0] r);
        return (r == 2'd3) ? RAIL_HIGH : r;
    endfunction
endpackage

// File: rtl/load_filter.sv
// Window-based load sampler with a first-order IIR smoother.
// Each window of WIN cycles yields x = level + WIN - stalls and then
// y <= y + ((x - y) >>> k). Assumes WIN >= 2 and that WIN is a power of two
// or smaller than 2**$clog2(WIN).
module load_filter #(
    parameter int OCC_W = 6,
    parameter int WIN   = 16,
    parameter int K_W   = 3,
    parameter int M_W   = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OCC_W-1:0] fifo_level,
    input  logic             stall,
    input  logic [K_W-1:0]   k_shift,
    output logic [M_W-1:0]   y,
    output logic             y_valid
);
    localparam int WIN_W = $clog2(WIN + 1);
    localparam int CNT_W = $clog2(WIN);
    localparam int MAX_X = (2 ** OCC_W - 1) + WIN;

    logic [CNT_W-1:0]      wcnt;
    logic [WIN_W-1:0]      scnt;
    logic [WIN_W-1:0]      stall_total;
    logic [M_W-1:0]        x;
    logic signed [M_W+1:0] diff;
    logic signed [M_W+1:0] step;
    logic signed [M_W+1:0] ysum;
    logic                  win_end;

    // Sample and filter-step arithmetic.
    always_comb begin
        win_end     = (wcnt == CNT_W'(WIN - 1));
        stall_total = scnt + {{(WIN_W-1){1'b0}}, stall};
        x           = M_W'(fifo_level) + M_W'(WIN) - M_W'(stall_total);
        diff        = $signed({2'b00, x}) - $signed({2'b00, y});
        step        = diff >>> k_shift;
        ysum        = $signed({2'b00, y}) + step;
    end

    // Window counter, stall counter and filter state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wcnt    <= '0;
            scnt    <= '0;
            y       <= '0;
            y_valid <= 1'b0;
        end else begin
            y_valid <= win_end;
            if (win_end) begin
                wcnt <= '0;
                scnt <= '0;
                y    <= ysum[M_W-1:0];
            end else begin
                wcnt <= wcnt + 1'b1;
                scnt <= stall_total;
            end
        end
    end

    AST_Y_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        int'(y) <= MAX_X); // R2
endmodule

// File: rtl/rail_selector.sv
// Chooses the target rail and frequency from three prioritised sources.
// The hardware loop applies hysteresis to the filtered load. A disconnect
// request is honoured only while the input FIFO is empty.
module rail_selector
    import tpg_pkg::*;
#(
    parameter int FREQ_W      = 6,
    parameter int M_W         = 7,
    parameter int HW_LOW_FREQ = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_en,
    input  logic [1:0]        sw_rail,
    input  logic [FREQ_W-1:0] sw_freq,
    input  logic              st_en,
    input  logic [1:0]        st_rail,
    input  logic [FREQ_W-1:0] st_freq,
    input  logic              fifo_empty,
    input  logic [M_W-1:0]    y,
    input  logic              y_valid,
    input  logic [M_W-1:0]    thr_high,
    input  logic [M_W-1:0]    thr_low,
    input  logic [1:0]        cur_rail,
    output logic [1:0]        tgt_rail,
    output logic [FREQ_W-1:0] tgt_freq
);
    logic [1:0]        hw_rail;
    logic [1:0]        req_rail;
    logic [FREQ_W-1:0] hw_freq;

    // Hysteresis decision, refreshed once per window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hw_rail <= RAIL_HIGH;
        end else if (y_valid) begin
            if (y > thr_high)     hw_rail <= RAIL_HIGH;
            else if (y < thr_low) hw_rail <= RAIL_LOW;
        end
    end

    // Source priority and disconnect gating.
    always_comb begin
        hw_freq = (hw_rail == RAIL_HIGH) ? {FREQ_W{1'b1}} : FREQ_W'(HW_LOW_FREQ);
        if (sw_en) begin
            req_rail = norm_rail(sw_rail);
            tgt_freq = sw_freq;
        end else if (st_en) begin
            req_rail = norm_rail(st_rail);
            tgt_freq = st_freq;
        end else begin
            req_rail = hw_rail;
            tgt_freq = hw_freq;
        end
        tgt_rail = (req_rail == RAIL_OFF && !fifo_empty) ? cur_rail : req_rail;
    end

    AST_OFF_NEEDS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_rail == RAIL_OFF && cur_rail != RAIL_OFF) |-> fifo_empty); // R5
    AST_HW_NEVER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        hw_rail != RAIL_OFF); // R3
endmodule

// File: rtl/rail_sequencer.sv
// Performs make-before-break rail switching while the core clock is halted.
// New gates are enabled one per ramp period, old gates are dropped together,
// and SETTLE_CYC cycles pass before the done pulse. Assumes GATE_N >= 2 and
// SETTLE_CYC >= 1. A target that changes mid-switch waits for the next one.
module rail_sequencer
    import tpg_pkg::*;
#(
    parameter int GATE_N     = 4,
    parameter int SETTLE_CYC = 3,
    parameter int FREQ_W     = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        tgt_rail,
    input  logic [FREQ_W-1:0] tgt_freq,
    input  logic [1:0]        ramp_sel,
    output logic [GATE_N-1:0] gate_high,
    output logic [GATE_N-1:0] gate_low,
    output logic              core_clk_en,
    output logic              switch_done,
    output logic [1:0]        rail_now,
    output logic [FREQ_W-1:0] freq_code
);
    localparam int IDX_W = $clog2(GATE_N);
    localparam int SET_W = $clog2(SETTLE_CYC + 1);

    seq_state_e        state;
    logic [1:0]        new_q;
    logic [FREQ_W-1:0] newf_q;
    logic [2:0]        per_q;
    logic [2:0]        period;
    logic [2:0]        stepc;
    logic [IDX_W-1:0]  idx;
    logic [SET_W-1:0]  setc;

    // Ramp period from the profile code.
    always_comb begin
        case (ramp_sel)
            2'd0:    period = 3'd1;
            2'd1:    period = 3'd2;
            default: period = 3'd4;
        endcase
        switch_done = (state == SQ_DONE);
        core_clk_en = (state == SQ_IDLE) && (rail_now != RAIL_OFF);
    end

    // Switch state machine and gate enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= SQ_IDLE;
            rail_now  <= RAIL_HIGH;
            new_q     <= RAIL_HIGH;
            newf_q    <= '1;
            freq_code <= '1;
            per_q     <= 3'd1;
            stepc     <= '0;
            idx       <= '0;
            setc      <= '0;
            gate_high <= '1;
            gate_low  <= '0;
        end else begin
            case (state)
                SQ_IDLE: begin
                    if (tgt_rail != rail_now) begin
                        new_q  <= tgt_rail;
                        newf_q <= tgt_freq;
                        per_q  <= period;
                        stepc  <= '0;
                        idx    <= '0;
                        state  <= SQ_RAMP_ON;
                    end else begin
                        freq_code <= tgt_freq;
                    end
                end
                SQ_RAMP_ON: begin
                    if (new_q == RAIL_OFF) begin
                        state <= SQ_RAMP_OFF;
                    end else if (stepc == per_q - 3'd1) begin
                        stepc <= '0;
                        if (new_q == RAIL_HIGH) gate_high[idx] <= 1'b1;
                        else                    gate_low[idx]  <= 1'b1;
                        idx <= idx + 1'b1;
                        if (idx == IDX_W'(GATE_N - 1)) state <= SQ_RAMP_OFF;
                    end else begin
                        stepc <= stepc + 3'd1;
                    end
                end
                SQ_RAMP_OFF: begin
                    if (new_q != RAIL_HIGH) gate_high <= '0;
                    if (new_q != RAIL_LOW)  gate_low  <= '0;
                    setc  <= '0;
                    state <= SQ_SETTLE;
                end
                SQ_SETTLE: begin
                    if (setc == SET_W'(SETTLE_CYC - 1)) state <= SQ_DONE;
                    else                                setc  <= setc + 1'b1;
                end
                SQ_DONE: begin
                    rail_now  <= new_q;
                    freq_code <= newf_q;
                    state     <= SQ_IDLE;
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    AST_GATE_ONE_STEP_HI: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(gate_high) <= $countones($past(gate_high)) + 1); // R6
    AST_GATE_ONE_STEP_LO: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(gate_low) <= $countones($past(gate_low)) + 1); // R6
    AST_BREAK_AFTER_MAKE_HI: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(gate_high) != '0 && gate_high == '0 && new_q == RAIL_LOW) |-> (&gate_low)); // R7
    AST_BREAK_AFTER_MAKE_LO: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(gate_low) != '0 && gate_low == '0 && new_q == RAIL_HIGH) |-> (&gate_high)); // R7
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        switch_done |=> !switch_done); // R8
endmodule

// File: rtl/tile_power_governor.sv
// Per-tile voltage and frequency governor: load filter, source selector and
// rail-switch sequencer. Produces only digital gate and clock enables.
// Assumes fifo_level is synchronous to clk.
module tile_power_governor
    import tpg_pkg::*;
#(
    parameter int OCC_W       = 6,
    parameter int WIN         = 16,
    parameter int FREQ_W      = 6,
    parameter int GATE_N      = 4,
    parameter int SETTLE_CYC  = 3,
    parameter int K_W         = 3,
    parameter int HW_LOW_FREQ = 20,
    localparam int M_W = ((OCC_W > $clog2(WIN + 1)) ? OCC_W : $clog2(WIN + 1)) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OCC_W-1:0]  fifo_level,
    input  logic              stall,
    input  logic              sw_en,
    input  logic [1:0]        sw_rail,
    input  logic [FREQ_W-1:0] sw_freq,
    input  logic              st_en,
    input  logic [1:0]        st_rail,
    input  logic [FREQ_W-1:0] st_freq,
    input  logic [K_W-1:0]    filt_shift,
    input  logic [M_W-1:0]    thr_high,
    input  logic [M_W-1:0]    thr_low,
    input  logic [1:0]        ramp_sel,
    output logic [FREQ_W-1:0] freq_code,
    output logic              core_clk_en,
    output logic [GATE_N-1:0] gate_high,
    output logic [GATE_N-1:0] gate_low,
    output logic              switch_done,
    output logic [1:0]        rail_now
);
    logic [M_W-1:0]    y;
    logic              y_valid;
    logic [1:0]        tgt_rail;
    logic [FREQ_W-1:0] tgt_freq;

    load_filter #(.OCC_W(OCC_W), .WIN(WIN), .K_W(K_W), .M_W(M_W)) u_filt (
        .clk(clk), .rst_n(rst_n), .fifo_level(fifo_level), .stall(stall),
        .k_shift(filt_shift), .y(y), .y_valid(y_valid)
    );

    rail_selector #(.FREQ_W(FREQ_W), .M_W(M_W), .HW_LOW_FREQ(HW_LOW_FREQ)) u_sel (
        .clk(clk), .rst_n(rst_n), .sw_en(sw_en), .sw_rail(sw_rail), .sw_freq(sw_freq),
        .st_en(st_en), .st_rail(st_rail), .st_freq(st_freq),
        .fifo_empty(fifo_level == '0), .y(y), .y_valid(y_valid),
        .thr_high(thr_high), .thr_low(thr_low), .cur_rail(rail_now),
        .tgt_rail(tgt_rail), .tgt_freq(tgt_freq)
    );

    rail_sequencer #(.GATE_N(GATE_N), .SETTLE_CYC(SETTLE_CYC), .FREQ_W(FREQ_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .tgt_rail(tgt_rail), .tgt_freq(tgt_freq),
        .ramp_sel(ramp_sel), .gate_high(gate_high), .gate_low(gate_low),
        .core_clk_en(core_clk_en), .switch_done(switch_done),
        .rail_now(rail_now), .freq_code(freq_code)
    );

    AST_HALT_ON_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_high != '0 && gate_low != '0) |-> !core_clk_en); // R6
    AST_REST_ONE_RAIL: assert property (@(posedge clk) disable iff (!rst_n)
        core_clk_en |-> ((&gate_high && gate_low == '0) || (&gate_low && gate_high == '0))); // R10
endmodule

// File: tb/tile_power_governor_test.sv
`timescale 1ns/1ps
module tile_power_governor_test;
    localparam int OCC_W = 6, WIN = 16, FREQ_W = 6, GATE_N = 4, SETTLE = 3, K_W = 3, LOWF = 20;
    localparam int M_W = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [OCC_W-1:0]  fifo_level = '0;
    logic              stall = 1'b0;
    logic              sw_en = 1'b1;
    logic [1:0]        sw_rail = 2'd2;
    logic [FREQ_W-1:0] sw_freq = 6'd63;
    logic              st_en = 1'b0;
    logic [1:0]        st_rail = 2'd2;
    logic [FREQ_W-1:0] st_freq = '0;
    logic [K_W-1:0]    filt_shift = '0;
    logic [M_W-1:0]    thr_high = 7'd40;
    logic [M_W-1:0]    thr_low = 7'd20;
    logic [1:0]        ramp_sel = 2'd0;
    logic [FREQ_W-1:0] freq_code;
    logic              core_clk_en, switch_done;
    logic [GATE_N-1:0] gate_high, gate_low;
    logic [1:0]        rail_now;

    int nchk = 0;
    int nfail = 0;

    always #2.5 clk = ~clk;

    tile_power_governor #(.OCC_W(OCC_W), .WIN(WIN), .FREQ_W(FREQ_W), .GATE_N(GATE_N),
        .SETTLE_CYC(SETTLE), .K_W(K_W), .HW_LOW_FREQ(LOWF)) uut (
        .clk(clk), .rst_n(rst_n), .fifo_level(fifo_level), .stall(stall),
        .sw_en(sw_en), .sw_rail(sw_rail), .sw_freq(sw_freq),
        .st_en(st_en), .st_rail(st_rail), .st_freq(st_freq),
        .filt_shift(filt_shift), .thr_high(thr_high), .thr_low(thr_low),
        .ramp_sel(ramp_sel), .freq_code(freq_code), .core_clk_en(core_clk_en),
        .gate_high(gate_high), .gate_low(gate_low), .switch_done(switch_done),
        .rail_now(rail_now)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    endtask

    // Waits for a halt, counts halted cycles up to the done pulse, checks gate order.
    task automatic measure(input logic [1:0] nr, input int oldf, output int halt, output int bad);
        int prev;
        logic [GATE_N-1:0] nv, ov;
        int guard = 0;
        halt = 0;
        bad = 0;
        prev = 0;
        while (core_clk_en && guard < 300) begin
            @(negedge clk);
            guard++;
        end
        forever begin
            halt++;
            nv = (nr == 2'd1) ? gate_low : gate_high;
            ov = (nr == 2'd1) ? gate_high : gate_low;
            if (nr != 2'd0) begin
                if ($countones(nv) > prev + 1) bad++;
                if (nv != '1 && ov != '1) bad++;
                prev = $countones(nv);
            end
            if (core_clk_en) bad++;
            if (int'(freq_code) != oldf && !switch_done) bad++;
            if (switch_done || halt > 200) break;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        chk(rail_now == 2'd2, "R1 rail", rail_now, 2);
        chk(gate_high == '1 && gate_low == '0, "R1 gates", {gate_high, gate_low}, 8'hF0);
        chk(core_clk_en == 1'b1 && switch_done == 1'b0, "R1 clk/done", {core_clk_en, switch_done}, 2);
        chk(freq_code == 6'd63, "R1 freq", freq_code, 63);
    endtask

    task automatic t_freq_follow();
        sw_freq = 6'd33;
        cyc(1);
        chk(freq_code == 6'd33, "R9 freq follows", freq_code, 33);
        chk(core_clk_en == 1'b1 && rail_now == 2'd2, "R9 no switch", rail_now, 2);
    endtask

    task automatic t_ramp(input int r, input int exp_halt);
        int h, b, of;
        ramp_sel = 2'(r);
        of = freq_code;
        sw_rail = 2'd1; sw_freq = 6'd12;
        measure(2'd1, of, h, b);
        chk(h == exp_halt, "R7 halt to low", h, exp_halt);
        chk(b == 0, "R6 ramp order to low", b, 0);
        cyc(1);
        chk(core_clk_en && rail_now == 2'd1, "R8 restart low", rail_now, 1);
        chk(gate_low == '1 && gate_high == '0, "R10 low gates", {gate_high, gate_low}, 8'h0F);
        chk(freq_code == 6'd12, "R9 freq after switch", freq_code, 12);
        of = freq_code;
        sw_rail = 2'd2; sw_freq = 6'd33;
        measure(2'd2, of, h, b);
        chk(h == exp_halt, "R7 halt to high", h, exp_halt);
        chk(b == 0, "R6 ramp order to high", b, 0);
        cyc(1);
        chk(core_clk_en && rail_now == 2'd2 && freq_code == 6'd33, "R8 restart high", rail_now, 2);
    endtask

    task automatic t_priority();
        int h, b;
        ramp_sel = 2'd0;
        st_en = 1'b1; st_rail = 2'd1; st_freq = 6'd9;
        cyc(40);
        chk(rail_now == 2'd2 && freq_code == 6'd33, "R4 sw over static", rail_now, 2);
        sw_en = 1'b0;
        measure(2'd1, 33, h, b);
        cyc(5);
        chk(rail_now == 2'd1 && freq_code == 6'd9, "R4 static applied", freq_code, 9);
        st_rail = 2'd3;
        cyc(40);
        chk(rail_now == 2'd2, "R5 code 3 is high", rail_now, 2);
        sw_en = 1'b1; sw_rail = 2'd2; sw_freq = 6'd33; st_en = 1'b0;
        cyc(5);
    endtask

    task automatic t_off();
        int h, b, dones = 0;
        fifo_level = 6'd5;
        sw_rail = 2'd0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (switch_done || !core_clk_en) dones++;
        end
        chk(dones == 0 && rail_now == 2'd2, "R5 off ignored when not empty", dones, 0);
        fifo_level = '0;
        measure(2'd0, 33, h, b);
        chk(h == SETTLE + 3, "R7 halt to off", h, SETTLE + 3);
        cyc(20);
        chk(!core_clk_en && gate_high == '0 && gate_low == '0 && rail_now == 2'd0,
            "R8 stays off", {core_clk_en, gate_high, gate_low}, 0);
        sw_rail = 2'd2;
        measure(2'd2, 33, h, b);
        cyc(1);
        chk(core_clk_en && gate_high == '1 && gate_low == '0, "R8 wake from off", gate_high, 15);
    endtask

    task automatic hw_latency(output int lat);
        lat = 0;
        while (core_clk_en && lat < 300) begin
            @(negedge clk);
            lat++;
        end
        while (!switch_done && lat < 600) @(negedge clk);
        cyc(2);
    endtask

    task automatic t_hw();
        int lat;
        ramp_sel = 2'd0; filt_shift = 3'd0; stall = 1'b0;
        fifo_level = 6'd30; sw_en = 1'b0; st_en = 1'b0;
        cyc(100);
        chk(rail_now == 2'd2 && freq_code == 6'd63, "R3 hw high", rail_now, 2);
        fifo_level = 6'd10;
        cyc(60);
        chk(rail_now == 2'd2, "R3 band keeps high", rail_now, 2);
        fifo_level = 6'd0;
        hw_latency(lat);
        chk(lat >= 3 && lat <= 18, "R2 k=0 one window", lat, 18);
        chk(rail_now == 2'd1 && freq_code == 6'(LOWF), "R3 hw low freq", freq_code, LOWF);
        fifo_level = 6'd10;
        cyc(60);
        chk(rail_now == 2'd1, "R3 band keeps low", rail_now, 1);
        fifo_level = 6'd24;
        cyc(60);
        chk(rail_now == 2'd1, "R3 equal to high threshold stays", rail_now, 1);
        fifo_level = 6'd25;
        cyc(60);
        chk(rail_now == 2'd2 && freq_code == 6'd63, "R3 above threshold", rail_now, 2);
        fifo_level = 6'd10;
        cyc(60);
        filt_shift = 3'd2; fifo_level = 6'd0;
        hw_latency(lat);
        chk(lat >= 35 && lat <= 50, "R2 k=2 three windows", lat, 35);
        filt_shift = 3'd0; fifo_level = 6'd30;
        cyc(80);
        chk(rail_now == 2'd2, "R2 back high", rail_now, 2);
        stall = 1'b1; fifo_level = 6'd10;
        cyc(80);
        chk(rail_now == 2'd1, "R2 stalls lower load", rail_now, 1);
    endtask

    initial begin
        #(5.0 * 150000);
        nchk++;
        nfail++;
        $display("FAIL watchdog actual=0 expected=1");
        finish_run();
    end

    initial begin
        cyc(4);
        rst_n = 1'b1;
        cyc(1);
        t_reset();
        t_freq_follow();
        t_ramp(0, GATE_N * 1 + SETTLE + 2);
        t_ramp(1, GATE_N * 2 + SETTLE + 2);
        t_ramp(2, GATE_N * 4 + SETTLE + 2);
        t_ramp(3, GATE_N * 4 + SETTLE + 2);
        t_priority();
        t_off();
        t_hw();
        finish_run();
    end
endmodule